// File: doc/BRIEF.md
# Synchronizable Chained PWM Channel

A single PWM generator channel driven by a free-running up-counter with a programmable period, a compare (duty) threshold, a selectable output polarity and a run/stop control. Period and compare values go through shadow registers so that updates made while the channel is running take effect only at the next counter wrap.

Several channels can be chained. The head of the chain ignores its sync input and drives a one-clock pulse on its sync output each time its counter reaches the period. Each downstream channel accepts the incoming pulse, reloads its counter with a programmable phase value, and either forwards the pulse, emits its own period pulse, or emits nothing. With periods chosen as integer fractions of the head's period, every channel stays locked to a common boundary and no beat frequency appears.

Configuration is through a small write-only port. Address 0 is the period, 1 the compare, 2 the phase, 3 the control word.

Top module: `sync_pwm_chan`

## Requirements
- R1: After reset the counter is 0 and stopped, all registers are 0, `pwm_o` is low and `sync_o` is low.
- R2: While running, the counter advances by one each clock from 0 up to the active period P, then returns to 0 on the next clock, so one PWM cycle lasts P+1 clocks.
- R3: With the run bit (control bit 0) clear, the counter holds its value and `pwm_o` does not change.
- R4: With the polarity bit (control bit 1) clear, `pwm_o` is high exactly while the counter is below the active compare value.
- R5: With the polarity bit set, `pwm_o` is the inverse of the R4 level.
- R6: A period or compare write becomes active on the clock where a running counter wraps from P, or on the next clock when the channel is stopped. Writes at any other time leave the active values unchanged.
- R7: When the sync-enable bit (control bit 2) is set, a high `sync_i` at a clock edge loads the phase register into the counter, whether the channel is running or stopped. When the bit is clear, `sync_i` has no effect on the counter.
- R8: An accepted sync that arrives on the clock where the counter would wrap takes priority: the counter becomes the phase value, not 0.
- R9: With sync-out select (control bits 4:3) equal to 2, `sync_o` is high for exactly the cycles in which a running counter equals the active period.
- R10: With sync-out select equal to 1, `sync_o` follows `sync_i`, combinationally when `SYNC_PASS_REG` is 0 and one clock later when it is 1.
- R11: With sync-out select equal to 0 or 3, `sync_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 period, 1 compare, 2 phase, 3 control |
| wr_data_i | input | CNT_W | Write data |
| sync_i | input | 1 | Sync pulse from the upstream channel |
| sync_o | output | 1 | Sync pulse toward the downstream channel |
| pwm_o | output | 1 | PWM output |

## Verification
A sync reload and a period wrap can fall on the same clock, and the design must resolve them in favour of the phase load. The bench provokes this by tracking its own model of the counter and raising `sync_i` exactly in the cycle where the model sits at the period, with phase values that differ from 0. It then judges the outcome by comparing `pwm_o` and the period pulse on `sync_o` on every following clock. A wrong winner shifts the PWM edges and moves the next period pulse. Shadow loads also coincide with wraps, so a period write made in the wrap cycle is exercised the same way.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
  typedef enum logic [1:0] {
    SO_OFF  = 2'd0,
    SO_PASS = 2'd1,
    SO_PRD  = 2'd2,
    SO_OFF2 = 2'd3
  } sync_sel_e;

  localparam int unsigned ADDR_W   = 2;
  localparam logic [1:0] A_PERIOD  = 2'd0;
  localparam logic [1:0] A_CMP     = 2'd1;
  localparam logic [1:0] A_PHASE   = 2'd2;
  localparam logic [1:0] A_CTRL    = 2'd3;

  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_POL    = 1;
  localparam int unsigned B_SIEN   = 2;
  localparam int unsigned B_SEL_LO = 3;
endpackage

// File: rtl/sync_pwm_regs.sv
module sync_pwm_regs
  import sync_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] prd_act_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic [CNT_W-1:0] phase_o,
  output logic             run_o,
  output logic             pol_o,
  output logic             sien_o,
  output sync_sel_e        osel_o
);
  logic [CNT_W-1:0] prd_sh_q, cmp_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_sh_q <= '0;
      cmp_sh_q <= '0;
      phase_o  <= '0;
      run_o    <= 1'b0;
      pol_o    <= 1'b0;
      sien_o   <= 1'b0;
      osel_o   <= SO_OFF;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_PERIOD: prd_sh_q <= wr_data_i;
        A_CMP:    cmp_sh_q <= wr_data_i;
        A_PHASE:  phase_o  <= wr_data_i;
        A_CTRL: begin
          run_o  <= wr_data_i[B_RUN];
          pol_o  <= wr_data_i[B_POL];
          sien_o <= wr_data_i[B_SIEN];
          osel_o <= sync_sel_e'(wr_data_i[B_SEL_LO+:2]);
        end
        default: ;
      endcase
    end
  end

  // shadow -> active transfer at wrap or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_act_o <= '0;
      cmp_act_o <= '0;
    end else if (load_i) begin
      prd_act_o <= prd_sh_q;
      cmp_act_o <= cmp_sh_q;
    end
  end
endmodule

// File: rtl/sync_pwm_tbase.sv
module sync_pwm_tbase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             sien_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             sacc_o
);
  assign sacc_o  = sync_i & sien_i;
  assign match_o = run_i & (cnt_o == prd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (sacc_o)   cnt_o <= phase_i;   // sync beats wrap
    else if (match_o)  cnt_o <= '0;
    else if (run_i)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sync_pwm_out.sv
module sync_pwm_out
  import sync_pwm_pkg::*;
#(
  parameter int unsigned CNT_W         = 16,
  parameter bit          SYNC_PASS_REG = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             pol_i,
  input  logic             match_i,
  input  logic             sync_i,
  input  sync_sel_e        osel_i,
  output logic             pwm_o,
  output logic             sync_o
);
  logic pass_sync;

  generate
    if (SYNC_PASS_REG) begin : g_pass_reg
      logic sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= sync_i;
      end
      assign pass_sync = sync_q;
    end else begin : g_pass_comb
      assign pass_sync = sync_i;
    end
  endgenerate

  assign pwm_o = (cnt_i < cmp_i) ^ pol_i;

  always_comb begin
    unique case (osel_i)
      SO_PASS: sync_o = pass_sync;
      SO_PRD:  sync_o = match_i;
      default: sync_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sync_pwm_chan.sv
module sync_pwm_chan
  import sync_pwm_pkg::*;
#(
  parameter int unsigned CNT_W         = 16,
  parameter bit          SYNC_PASS_REG = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             sync_i,
  output logic             sync_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] prd_act, cmp_act, phase, cnt;
  logic             run, pol, sien, match, sacc;
  sync_sel_e        osel;

  sync_pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i   (~run | match),
    .prd_act_o(prd_act),
    .cmp_act_o(cmp_act),
    .phase_o  (phase),
    .run_o    (run),
    .pol_o    (pol),
    .sien_o   (sien),
    .osel_o   (osel)
  );

  sync_pwm_tbase #(.CNT_W(CNT_W)) u_tbase (
    .clk_i, .rst_ni,
    .run_i  (run),
    .sien_i (sien),
    .sync_i,
    .phase_i(phase),
    .prd_i  (prd_act),
    .cnt_o  (cnt),
    .match_o(match),
    .sacc_o (sacc)
  );

  sync_pwm_out #(.CNT_W(CNT_W), .SYNC_PASS_REG(SYNC_PASS_REG)) u_out (
    .clk_i, .rst_ni,
    .cnt_i  (cnt),
    .cmp_i  (cmp_act),
    .pol_i  (pol),
    .match_i(match),
    .sync_i,
    .osel_i (osel),
    .pwm_o,
    .sync_o
  );
endmodule

// File: rtl/sync_pwm_chk.sv
module sync_pwm_chk
  import sync_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             sync_i,
  input logic             sync_o,
  input logic             pwm_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd_act,
  input logic [CNT_W-1:0] phase,
  input logic             run,
  input logic             sien,
  input sync_sel_e        osel
);
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && cnt == prd_act && !(sync_i && sien) |=> cnt == '0); // R2

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && cnt < prd_act && !(sync_i && sien) |=> cnt == $past(cnt) + 1'b1); // R2

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && !(sync_i && sien) && !wr_en_i |=> $stable(cnt) && $stable(pwm_o)); // R3

  AST_SYNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i && sien |=> cnt == $past(phase)); // R7

  AST_SYNC_BEATS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i && sien && run && cnt == prd_act |=> cnt == $past(phase)); // R8

  AST_PRD_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osel == SO_PRD && sync_o && !sync_i && prd_act != '0 && !wr_en_i |=> !sync_o); // R9

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osel == SO_OFF || osel == SO_OFF2) |-> !sync_o); // R11
endmodule

bind sync_pwm_chan sync_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .sync_i, .sync_o, .pwm_o,
  .cnt, .prd_act, .phase, .run, .sien, .osel
);

// File: tb/sim_sync_pwm_chan.sv
module sim_sync_pwm_chan;
  localparam int CLK_PER = 10;
  localparam int CW      = 16;
  localparam int WDOG    = 50000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    wa = '0;
  logic [CW-1:0] wd = '0;
  logic          si = 1'b0;
  logic          so, pwm;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  // reference model state
  int m_cnt, m_prd_s, m_cmp_s, m_prd_a, m_cmp_a, m_phase;
  bit m_run, m_pol, m_sien, m_si_q;
  int m_sel;

  always #(CLK_PER/2) clk = ~clk;

  sync_pwm_chan #(.CNT_W(CW), .SYNC_PASS_REG(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(wa),
    .wr_data_i(wd), .sync_i(si), .sync_o(so), .pwm_o(pwm)
  );

  task automatic chk(input string t, input string what, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", t, what, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_prd_s = 0; m_cmp_s = 0; m_prd_a = 0; m_cmp_a = 0; m_phase = 0;
    m_run = 0; m_pol = 0; m_sien = 0; m_si_q = 0; m_sel = 0;
  endtask

  // one clock: drive, compare, advance model
  task automatic step(input bit w, input int a, input int d, input bit s);
    bit e_pwm, e_so, sacc, match;
    @(negedge clk);
    we = w; wa = 2'(a); wd = CW'(d); si = s;
    #1;
    e_pwm = (m_cnt < m_cmp_a) ^ m_pol;
    case (m_sel)
      1: e_so = s;
      2: e_so = m_run && (m_cnt == m_prd_a);
      default: e_so = 1'b0;
    endcase
    if (rst_n) begin
      chk(tag, "pwm_o", pwm, e_pwm);
      chk(tag, "sync_o", so, e_so);
    end
    @(posedge clk);
    cyc++;
    if (!rst_n) begin model_reset(); return; end
    sacc  = s && m_sien;
    match = m_run && (m_cnt == m_prd_a);
    if (!m_run || match) begin m_prd_a = m_prd_s; m_cmp_a = m_cmp_s; end
    if (sacc)       m_cnt = m_phase;
    else if (match) m_cnt = 0;
    else if (m_run) m_cnt = m_cnt + 1;
    m_si_q = s;
    if (w) begin
      case (a)
        0: m_prd_s = d;
        1: m_cmp_s = d;
        2: m_phase = d;
        default: begin
          m_run = d[0]; m_pol = d[1]; m_sien = d[2]; m_sel = (d >> 3) & 3;
        end
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  function automatic int ctrl(bit run, bit pol, bit sien, int sel);
    return int'(run) | (int'(pol) << 1) | (int'(sien) << 2) | (sel << 3);
  endfunction

  initial begin : watchdog
    #(CLK_PER * WDOG);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    // R1: reset state
    @(negedge clk); rst_n = 1'b1;
    tag = "R1";
    chk("R1", "pwm_o after reset", pwm, 1'b0);
    chk("R1", "sync_o after reset", so, 1'b0);
    idle(3);

    // R2 R4 R9: basic run, period pulse
    tag = "R2";
    step(1, 0, 9, 0); step(1, 1, 4, 0);
    step(1, 3, ctrl(1, 0, 0, 2), 0);
    idle(25);
    tag = "R9"; idle(12);
    tag = "R4"; step(1, 1, 0, 0); idle(22); step(1, 1, 10, 0); idle(22);

    // R6: shadow updates while running
    tag = "R6";
    step(1, 1, 3, 0); step(1, 0, 5, 0); idle(30);
    // write exactly at a wrap cycle
    while (m_cnt != m_prd_a) step(0, 0, 0, 0);
    step(1, 0, 7, 0); idle(20);

    // R5: polarity
    tag = "R5";
    step(1, 3, ctrl(1, 1, 0, 2), 0); idle(20);

    // R3: stop holds, R6 while stopped
    tag = "R3";
    idle(3);
    step(1, 3, ctrl(0, 0, 0, 2), 0); idle(10);
    step(0, 0, 0, 1); idle(4);
    tag = "R6";
    step(1, 1, 2, 0); step(1, 0, 4, 0); idle(4);
    step(1, 3, ctrl(1, 0, 0, 2), 0); idle(15);

    // R7: sync ignored when disabled, loads phase when enabled
    tag = "R7";
    step(1, 2, 3, 0);
    for (int i = 0; i < 6; i++) begin step(0, 0, 0, 1); idle(3); end
    step(1, 3, ctrl(1, 0, 1, 2), 0);
    for (int i = 0; i < 8; i++) begin step(0, 0, 0, 1); idle(2 + i); end
    // sync while stopped
    step(1, 3, ctrl(0, 0, 1, 2), 0); idle(2);
    step(1, 2, 1, 0); step(0, 0, 0, 1); idle(3);
    step(1, 3, ctrl(1, 0, 1, 2), 0); idle(8);

    // R8: sync on the wrap cycle
    tag = "R8";
    step(1, 0, 8, 0); step(1, 1, 5, 0); step(1, 2, 2, 0); idle(12);
    for (int k = 0; k < 5; k++) begin
      while (m_cnt != m_prd_a) step(0, 0, 0, 0);
      step(0, 0, 0, 1);
      idle(6);
    end
    step(1, 2, 6, 0);
    while (m_cnt != m_prd_a) step(0, 0, 0, 0);
    step(0, 0, 0, 1); idle(12);

    // R10: pass-through
    tag = "R10";
    step(1, 3, ctrl(1, 0, 1, 1), 0);
    for (int i = 0; i < 40; i++) step(0, 0, 0, bit'((i * 7 + 3) % 5 == 0));

    // R11: disabled output, both codes
    tag = "R11";
    step(1, 3, ctrl(1, 0, 1, 0), 0);
    for (int i = 0; i < 30; i++) step(0, 0, 0, bit'(i % 3 == 0));
    step(1, 3, ctrl(1, 0, 1, 3), 0);
    for (int i = 0; i < 30; i++) step(0, 0, 0, bit'(i % 4 == 1));

    // R2: harmonic periods, long run
    tag = "R2";
    step(1, 3, ctrl(1, 0, 0, 2), 0);
    step(1, 0, 39, 0); step(1, 1, 20, 0); idle(120);
    step(1, 0, 0, 0); idle(10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule